// File: doc/BRIEF.md
# Serial Configuration Register Target

This block is the control-port target of a configurable peripheral. A host reaches it over a four-wire serial link: a clock that idles high, an active-low latch, a data input and a data output. Through that link the host reads and writes a bank of seventeen 8-bit configuration registers. The surrounding logic sees every register at all times on one flat output bus. One bit of the bank does not hold stored data. It shows a live status input, such as a clock-lock flag.

Each transaction is a 24-bit frame sent most significant bit first. The frame holds a 7-bit device address, a direction bit, an 8-bit register index and a data byte. A write is applied only when the latch returns high, and only if the frame was complete and addressed to this device. A read is answered in the third byte: the addressed register is shifted out on the serial output while the host clocks in bytes it does not use. All serial inputs pass through two-flop synchronizers and are sampled by the fast system clock, so the serial clock must run well below the system clock. The bench uses a serial bit time of 16 system cycles.

Top module: `ctlport_target`

## Requirements
- R1: A frame is 24 bits, most significant bit first, sampled on rising serial-clock edges while the latch is low. The fields are: bits 23:17 device address, bit 16 direction (1 = read, 0 = write), bits 15:8 register index, bits 7:0 data.
- R2: A write frame with device address 0x04 and index 0 to 16 updates that register once the latch rises. The register appears on `cfg_regs` at bits index*8+7 down to index*8.
- R3: A read frame with device address 0x04 and index 0 to 16 returns the register on `spi_miso` during bits 16 to 23 of the frame, most significant bit first. Each bit changes on a falling serial-clock edge, so the host can sample it on the following rising edge.
- R4: A frame whose device address is not 0x04 changes no register, and if it is a read, returns 0x00.
- R5: A frame whose index is above 16 changes no register, and if it is a read, returns 0x00.
- R6: A write frame that delivers fewer or more than 24 bits before the latch rises is discarded.
- R7: Bit 3 of register 1 always reflects `lock_in`, both on `cfg_regs` and in read-back. Host writes to that bit have no effect.
- R8: A synchronous active-high reset clears every register to 0x00 and drives `spi_miso` low.
- R9: `spi_miso` is low whenever the latch is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from the host, idles high |
| spi_csn | input | 1 | Active-low frame latch from the host |
| spi_mosi | input | 1 | Serial data from the host |
| lock_in | input | 1 | Status level shown in register 1 bit 3 |
| spi_miso | output | 1 | Serial read data to the host |
| cfg_regs | output | 136 | All registers, register n at bits n*8+7:n*8 |

## Verification
The bench goes after frame-length errors, with 23-bit and 25-bit writes. A design that commits on the 24th bit, or that does not detect an overrun, would take these writes. It sends frames with a foreign device address and with indices 17 and 255. A design that truncates the index or ignores the address would corrupt a real register or return stale data. It writes all ones to register 1 with the status input low, then reads register 1 with the status input high. A design that stores the status bit, or leaves it out of read-back, shows the wrong bit 3. The top index 16 and a bit-order pattern such as 0x81 expose off-by-one bank sizing and a reversed shift direction.

// File: rtl/ctlport_pkg.sv
package ctlport_pkg;

    localparam int REG_W      = 8;
    localparam int FRAME_BITS = 24;
    localparam int HDR_BITS   = 16;
    localparam int CNT_W      = $clog2(FRAME_BITS + 2);

    typedef struct packed {
        logic [6:0]       dev;
        logic             rd;
        logic [REG_W-1:0] idx;
    } hdr_t;

    typedef struct packed {
        hdr_t             hdr;
        logic [REG_W-1:0] data;
    } frame_t;

    function automatic logic idx_in_range(input logic [REG_W-1:0] idx, input int num);
        return int'(idx) < num;
    endfunction

endpackage

// File: rtl/ctlport_sync.sv
module ctlport_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= RST_VAL;
            else     chain[s] <= (s == 0) ? d_in : chain[(s == 0) ? 0 : s-1];
        end
    end

    assign d_out = chain[STAGES-1];
endmodule

// File: rtl/ctlport_frame_rx.sv
module ctlport_frame_rx import ctlport_pkg::*; #(
    parameter int         NUM_REGS = 17,
    parameter logic [6:0] DEV_ADDR = 7'h04
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sclk_s,
    input  logic             csn_s,
    input  logic             mosi_s,
    output logic             sclk_fall,
    output logic             wr_en,
    output logic [REG_W-1:0] wr_idx,
    output logic [REG_W-1:0] wr_data,
    output logic             rd_load,
    output logic             rd_hit,
    output logic [REG_W-1:0] rd_idx
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_BITS - 1);

    logic                  sclk_d, csn_d;
    logic                  sclk_rise, csn_rise;
    logic [CNT_W-1:0]      bit_cnt;
    logic [FRAME_BITS-1:0] shreg;
    logic                  hdr_seen;
    frame_t                frm;
    hdr_t                  hdr;
    logic                  commit;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= 1'b1;
            csn_d  <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            csn_d  <= csn_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_d;
    assign sclk_fall = ~sclk_s & sclk_d;
    assign csn_rise  = csn_s & ~csn_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (csn_s) begin
            bit_cnt <= '0;
        end else if (sclk_rise) begin
            shreg <= {shreg[FRAME_BITS-2:0], mosi_s};
            if (bit_cnt != CNT_OVER) bit_cnt <= bit_cnt + 1'b1;
        end
    end

    assign frm = frame_t'(shreg);
    assign hdr = hdr_t'(shreg[HDR_BITS-1:0]);

    assign commit = csn_rise && (bit_cnt == CNT_FULL) && (frm.hdr.dev == DEV_ADDR)
                    && !frm.hdr.rd && idx_in_range(frm.hdr.idx, NUM_REGS);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en    <= 1'b0;
            wr_idx   <= '0;
            wr_data  <= '0;
            hdr_seen <= 1'b0;
        end else begin
            wr_en    <= commit;
            hdr_seen <= sclk_rise && !csn_s && (bit_cnt == CNT_HDR);
            if (commit) begin
                wr_idx  <= frm.hdr.idx;
                wr_data <= frm.data;
            end
        end
    end

    assign rd_load = hdr_seen;
    assign rd_hit  = (hdr.dev == DEV_ADDR) && hdr.rd && idx_in_range(hdr.idx, NUM_REGS);
    assign rd_idx  = hdr.idx;

    // R6: a write commit is a single-cycle strobe per frame
    a_r6_single_commit: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    // R1: the bit counter clears once the latch is sampled high
    a_r1_count_clear: assert property (@(posedge clk) disable iff (rst)
        csn_s |=> (bit_cnt == '0));
endmodule

// File: rtl/ctlport_reg_bank.sv
module ctlport_reg_bank import ctlport_pkg::*; #(
    parameter int NUM_REGS   = 17,
    parameter int STATUS_REG = 1,
    parameter int STATUS_BIT = 3
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [REG_W-1:0]               wr_idx,
    input  logic [REG_W-1:0]               wr_data,
    input  logic                           status_s,
    input  logic [REG_W-1:0]               rd_idx,
    output logic [REG_W-1:0]               rd_data,
    output logic [NUM_REGS-1:0][REG_W-1:0] view
);
    localparam logic [REG_W-1:0] STATUS_MASK = REG_W'(1) << STATUS_BIT;

    logic [NUM_REGS-1:0][REG_W-1:0] store;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam logic [REG_W-1:0] WMASK = (i == STATUS_REG) ? ~STATUS_MASK : '1;
        always_ff @(posedge clk) begin
            if (rst)                                   store[i] <= '0;
            else if (wr_en && wr_idx == REG_W'(i))     store[i] <= wr_data & WMASK;
        end
    end

    always_comb begin
        view = store;
        view[STATUS_REG][STATUS_BIT] = status_s;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (rd_idx == REG_W'(i)) rd_data = view[i];
    end

    // R2: the stored bank moves only on a commit strobe
    a_r2_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> (store == $past(store)));

    // R5: commit strobes only ever carry an in-range index
    a_r5_index_in_range: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (int'(wr_idx) < NUM_REGS));
endmodule

// File: rtl/ctlport_read_tx.sv
module ctlport_read_tx import ctlport_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             csn_s,
    input  logic             sclk_fall,
    input  logic             load,
    input  logic [REG_W-1:0] load_val,
    output logic             miso
);
    logic [REG_W-1:0] out_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_sh <= '0;
            miso   <= 1'b0;
        end else if (csn_s) begin
            out_sh <= '0;
            miso   <= 1'b0;
        end else if (load) begin
            out_sh <= load_val;
        end else if (sclk_fall) begin
            miso   <= out_sh[REG_W-1];
            out_sh <= {out_sh[REG_W-2:0], 1'b0};
        end
    end

    // R9: output is quiet once the latch is seen high
    a_r9_idle_low: assert property (@(posedge clk) disable iff (rst)
        csn_s |=> !miso);

    // R3: output only moves on a falling serial clock edge
    a_r3_change_on_fall: assert property (@(posedge clk) disable iff (rst)
        (!csn_s && !sclk_fall) |=> $stable(miso));
endmodule

// File: rtl/ctlport_target.sv
module ctlport_target import ctlport_pkg::*; #(
    parameter int         NUM_REGS    = 17,
    parameter logic [6:0] DEV_ADDR    = 7'h04,
    parameter int         STATUS_REG  = 1,
    parameter int         STATUS_BIT  = 3,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      spi_sclk,
    input  logic                      spi_csn,
    input  logic                      spi_mosi,
    input  logic                      lock_in,
    output logic                      spi_miso,
    output logic [NUM_REGS*REG_W-1:0] cfg_regs
);
    logic sclk_s, csn_s, mosi_s, lock_s;
    logic sclk_fall, wr_en, rd_load, rd_hit;
    logic [REG_W-1:0] wr_idx, wr_data, rd_idx, bank_rd, load_val;
    logic [NUM_REGS-1:0][REG_W-1:0] view;

    ctlport_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sclk (
        .clk(clk), .rst(rst), .d_in(spi_sclk), .d_out(sclk_s));
    ctlport_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_csn (
        .clk(clk), .rst(rst), .d_in(spi_csn), .d_out(csn_s));
    ctlport_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi (
        .clk(clk), .rst(rst), .d_in(spi_mosi), .d_out(mosi_s));
    ctlport_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_lock (
        .clk(clk), .rst(rst), .d_in(lock_in), .d_out(lock_s));

    ctlport_frame_rx #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR)) u_rx (
        .clk(clk), .rst(rst), .sclk_s(sclk_s), .csn_s(csn_s), .mosi_s(mosi_s),
        .sclk_fall(sclk_fall), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_load(rd_load), .rd_hit(rd_hit), .rd_idx(rd_idx));

    ctlport_reg_bank #(.NUM_REGS(NUM_REGS), .STATUS_REG(STATUS_REG),
                       .STATUS_BIT(STATUS_BIT)) u_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .status_s(lock_s), .rd_idx(rd_idx), .rd_data(bank_rd), .view(view));

    assign load_val = rd_hit ? bank_rd : '0;

    ctlport_read_tx u_tx (
        .clk(clk), .rst(rst), .csn_s(csn_s), .sclk_fall(sclk_fall),
        .load(rd_load), .load_val(load_val), .miso(spi_miso));

    assign cfg_regs = view;
endmodule

// File: tb/ctlport_target_tb.sv
module ctlport_target_tb_top;
    localparam int NREG = 17;
    localparam int HALF = 8;

    typedef struct packed {
        logic [6:0] dev;
        logic [7:0] idx;
        logic [7:0] data;
        logic [7:0] nbits;
        logic [7:0] exp_rd;
        logic       upd;
        logic [7:0] req;
    } vec_t;

    localparam vec_t VEC [10] = '{
        '{7'h04, 8'd0,   8'hA5, 8'd24, 8'hA5, 1'b1, 8'd2}, // R2 basic write
        '{7'h04, 8'd16,  8'h3C, 8'd24, 8'h3C, 1'b1, 8'd2}, // R2 top index
        '{7'h04, 8'd1,   8'hFF, 8'd24, 8'hF7, 1'b1, 8'd7}, // R7 status bit not stored
        '{7'h05, 8'd0,   8'h11, 8'd24, 8'hA5, 1'b0, 8'd4}, // R4 foreign device
        '{7'h04, 8'd0,   8'h22, 8'd23, 8'hA5, 1'b0, 8'd6}, // R6 short frame
        '{7'h04, 8'd0,   8'h22, 8'd25, 8'hA5, 1'b0, 8'd6}, // R6 long frame
        '{7'h04, 8'd6,   8'h80, 8'd24, 8'h80, 1'b1, 8'd3}, // R3 read-back MSB
        '{7'h04, 8'd17,  8'h55, 8'd24, 8'h00, 1'b0, 8'd5}, // R5 first index past end
        '{7'h04, 8'd255, 8'h55, 8'd24, 8'h00, 1'b0, 8'd5}, // R5 largest index
        '{7'h04, 8'd16,  8'h01, 8'd24, 8'h01, 1'b1, 8'd3}  // R3 read-back LSB
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic spi_sclk = 1'b1;
    logic spi_csn = 1'b1;
    logic spi_mosi = 1'b0;
    logic lock_in = 1'b0;
    logic spi_miso;
    logic [NREG*8-1:0] cfg_regs;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    ctlport_target dut_i (
        .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_csn(spi_csn),
        .spi_mosi(spi_mosi), .lock_in(lock_in), .spi_miso(spi_miso),
        .cfg_regs(cfg_regs));

    task automatic check(input logic ok, input string req, input logic [135:0] act,
                         input logic [135:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [23:0] f, input int nbits, output logic [7:0] rd);
        rd = '0;
        spi_csn = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < nbits; i++) begin
            spi_sclk = 1'b0;
            spi_mosi = (i < 24) ? f[23-i] : 1'b0;
            wait_clk(HALF);
            if (i >= 16 && i < 24) rd = {rd[6:0], spi_miso};
            spi_sclk = 1'b1;
            wait_clk(HALF);
        end
        wait_clk(HALF);
        spi_csn = 1'b1;
        wait_clk(12);
    endtask

    task automatic reg_write(input logic [6:0] dev, input logic [7:0] idx,
                             input logic [7:0] data, input int nbits);
        logic [7:0] dummy;
        send_frame({dev, 1'b0, idx, data}, nbits, dummy);
    endtask

    task automatic reg_read(input logic [6:0] dev, input logic [7:0] idx, output logic [7:0] v);
        send_frame({dev, 1'b1, idx, 8'h00}, 24, v);
    endtask

    initial begin
        logic [7:0] rv;
        logic [NREG*8-1:0] snap;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(5);

        // R8: reset state
        check(cfg_regs == '0, "R8 reset regs", 136'(cfg_regs), 136'(0));
        check(spi_miso == 1'b0, "R8 reset miso", 136'(spi_miso), 136'(0));

        for (int k = 0; k < 10; k++) begin
            snap = cfg_regs;
            reg_write(VEC[k].dev, VEC[k].idx, VEC[k].data, int'(VEC[k].nbits));
            if (VEC[k].upd)
                check(cfg_regs[int'(VEC[k].idx)*8 +: 8] == VEC[k].exp_rd,
                      $sformatf("R%0d bus vec %0d", VEC[k].req, k),
                      136'(cfg_regs[int'(VEC[k].idx)*8 +: 8]), 136'(VEC[k].exp_rd));
            else
                check(cfg_regs == snap, $sformatf("R%0d unchanged vec %0d", VEC[k].req, k),
                      136'(cfg_regs), 136'(snap));
            reg_read(7'h04, VEC[k].idx, rv);
            check(rv == VEC[k].exp_rd, $sformatf("R%0d readback vec %0d", VEC[k].req, k),
                  136'(rv), 136'(VEC[k].exp_rd));
        end

        // R1: bit order through a pattern with distinct ends
        reg_write(7'h04, 8'd2, 8'h81, 24);
        reg_read(7'h04, 8'd2, rv);
        check(rv == 8'h81, "R1 bit order", 136'(rv), 136'h81);

        // R7: status shown live on bus and read-back
        lock_in = 1'b1;
        wait_clk(10);
        check(cfg_regs[11] == 1'b1, "R7 bus status", 136'(cfg_regs[11]), 136'(1));
        reg_read(7'h04, 8'd1, rv);
        check(rv == 8'hFF, "R7 read status high", 136'(rv), 136'hFF);
        reg_write(7'h04, 8'd1, 8'h00, 24);
        reg_read(7'h04, 8'd1, rv);
        check(rv == 8'h08, "R7 write cannot clear status", 136'(rv), 136'h08);

        // R4: read with foreign device address
        reg_read(7'h05, 8'd0, rv);
        check(rv == 8'h00, "R4 foreign read", 136'(rv), 136'h00);

        // R9: latch high after a read that ended on a one
        reg_write(7'h04, 8'd3, 8'hFF, 24);
        reg_read(7'h04, 8'd3, rv);
        check(rv == 8'hFF, "R3 all ones", 136'(rv), 136'hFF);
        check(spi_miso == 1'b0, "R9 idle miso", 136'(spi_miso), 136'(0));

        // R8: reset again clears the bank
        lock_in = 1'b0;
        wait_clk(5);
        rst = 1'b1;
        wait_clk(3);
        rst = 1'b0;
        wait_clk(5);
        check(cfg_regs == '0, "R8 second reset", 136'(cfg_regs), 136'(0));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R0 watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule